// File: doc/BRIEF.md
# Dual Reference Switchover Controller

This block decides which of two reference clocks drives the downstream loop and whether that loop should coast in holdover. It has two control paths of the same shape: one for the reference choice and one for holdover. Each path is either automatic, where an internal state machine fed by two reference-validity flags makes the choice, or manual, where a level on an external pin makes it. A register-level override can then force the path to a fixed value. It does not switch the clocks itself. It only produces the decisions.

Each path has a bidirectional status pin, modelled as separate input, output and output-enable signals. In automatic mode the pin is driven with the state machine's decision. This continues while an override is forcing the real outcome, so software can force a switchover and still watch how the machine would respond. The state machine keeps evaluating the validity flags in every mode. Each change of an actual decision is marked by a one-cycle strobe.

Top module: `refsw_ctrl`

## Requirements
- R1: While reset is asserted, and until the first input change after release, `act_ref_b`, `act_hold`, both strobes, `sel_pin_o` and `hold_pin_o` are 0. Here 0 means reference A and not in holdover.
- R2: With `auto_sel_en`=0 and no selection override, `sel_pin_oe` is 0 and `act_ref_b` takes the level of `sel_pin_i` (0 = A, 1 = B) at the next clock edge.
- R3: With `auto_sel_en`=1 and no selection override, `sel_pin_oe` is 1, `sel_pin_o` shows the machine's reference, and `act_ref_b` equals that reference from the same edge on.
- R4: With `sel_ovr_en`=1, `act_ref_b` takes `force_ref_b` at the next edge. `sel_pin_o` keeps reporting the machine's own reference.
- R5: Holdover uses the same scheme. `hold_pin_oe` equals `auto_hold_en`. In manual mode `act_hold` follows `hold_pin_i`. With `hold_ovr_en`=1, `act_hold` takes `force_hold` while `hold_pin_o` keeps showing the machine's holdover decision.
- R6: When not in holdover, the machine stays on its current reference while that reference is valid. It moves to the other reference when the current one is invalid and the other is valid.
- R7: When neither validity flag is set, the machine enters holdover at the next edge and keeps its reference choice.
- R8: From holdover the machine leaves for the first reference seen valid. If both become valid in the same cycle, it takes reference A.
- R9: `sel_chg_stb` and `hold_chg_stb` pulse high for exactly one cycle, on the same edge at which `act_ref_b` or `act_hold` changes, and stay low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a_ok | input | 1 | Reference A within limits |
| ref_b_ok | input | 1 | Reference B within limits |
| auto_sel_en | input | 1 | Reference choice by state machine (1) or by pin (0) |
| auto_hold_en | input | 1 | Holdover by state machine (1) or by pin (0) |
| sel_ovr_en | input | 1 | Force the reference choice from `force_ref_b` |
| hold_ovr_en | input | 1 | Force holdover from `force_hold` |
| force_ref_b | input | 1 | Forced reference, 1 = B |
| force_hold | input | 1 | Forced holdover state |
| sel_pin_i | input | 1 | Select pin level in manual mode |
| sel_pin_o | output | 1 | Machine reference choice driven onto select pin |
| sel_pin_oe | output | 1 | Select pin driver enable |
| hold_pin_i | input | 1 | Holdover pin level in manual mode |
| hold_pin_o | output | 1 | Machine holdover decision driven onto holdover pin |
| hold_pin_oe | output | 1 | Holdover pin driver enable |
| act_ref_b | output | 1 | Active reference, 1 = B |
| act_hold | output | 1 | Active holdover state |
| sel_chg_stb | output | 1 | One-cycle pulse on change of `act_ref_b` |
| hold_chg_stb | output | 1 | One-cycle pulse on change of `act_hold` |

## Verification
Every registered result is due at the first clock edge after its stimulus. This covers the actual selection, the actual holdover state, the machine's pin reports and the change strobes. The output enables follow the mode bits with no delay. The bench changes inputs in the middle of a cycle, waits for one rising edge, and samples one time unit later. Each strobe is therefore checked in the single cycle it is due, and again one cycle later, when it must have dropped.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

  // Encoding: bit 0 = reference B chosen, bit 1 = in holdover
  typedef enum logic [1:0] {
    ST_ON_A   = 2'b00,
    ST_ON_B   = 2'b01,
    ST_HOLD_A = 2'b10,
    ST_HOLD_B = 2'b11
  } refsw_st_e;

  typedef struct packed {
    logic hold;
    logic ref_b;
  } refsw_pick_t;

  localparam int unsigned NUM_PATH  = 2;
  localparam int unsigned PATH_SEL  = 0;
  localparam int unsigned PATH_HOLD = 1;

  function automatic refsw_pick_t st_to_pick(refsw_st_e st);
    refsw_pick_t p;
    p.ref_b = st[0];
    p.hold  = st[1];
    return p;
  endfunction

endpackage

// File: rtl/refsw_auto_fsm.sv
module refsw_auto_fsm
  import refsw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ok_a,
  input  logic        ok_b,
  output refsw_pick_t pick_d,
  output refsw_pick_t pick_q
);

  refsw_st_e st_q;
  refsw_st_e st_d;
  logic      st_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ON_A: begin
        if (!ok_a) begin
          if (ok_b) st_d = ST_ON_B;
          else      st_d = ST_HOLD_A;
        end
      end
      ST_ON_B: begin
        if (!ok_b) begin
          if (ok_a) st_d = ST_ON_A;
          else      st_d = ST_HOLD_B;
        end
      end
      ST_HOLD_A, ST_HOLD_B: begin
        if (ok_a)      st_d = ST_ON_A;
        else if (ok_b) st_d = ST_ON_B;
      end
      default: st_d = ST_ON_A;
    endcase
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_ON_A;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign pick_d = st_to_pick(st_d);
  assign pick_q = st_to_pick(st_q);

endmodule

// File: rtl/refsw_path.sv
module refsw_path (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic ovr_en,
  input  logic ovr_val,
  input  logic pin_in,
  input  logic mach_d,
  input  logic mach_q,
  output logic pin_out,
  output logic pin_oe,
  output logic act_q,
  output logic chg_stb
);

  logic mach_pick;
  logic act_d;
  logic act_en;
  logic stb_d;

  always_comb begin
    mach_pick = auto_en ? mach_d : pin_in;
    act_d     = ovr_en ? ovr_val : mach_pick;
    act_en    = (act_d != act_q);
    stb_d     = act_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_stb <= 1'b0;
    end else begin
      chg_stb <= stb_d;
    end
  end

  assign pin_out = mach_q;
  assign pin_oe  = auto_en;

endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
  import refsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_a_ok,
  input  logic ref_b_ok,
  input  logic auto_sel_en,
  input  logic auto_hold_en,
  input  logic sel_ovr_en,
  input  logic hold_ovr_en,
  input  logic force_ref_b,
  input  logic force_hold,
  input  logic sel_pin_i,
  output logic sel_pin_o,
  output logic sel_pin_oe,
  input  logic hold_pin_i,
  output logic hold_pin_o,
  output logic hold_pin_oe,
  output logic act_ref_b,
  output logic act_hold,
  output logic sel_chg_stb,
  output logic hold_chg_stb
);

  refsw_pick_t fsm_d;
  refsw_pick_t fsm_q;

  logic [NUM_PATH-1:0] p_auto;
  logic [NUM_PATH-1:0] p_ovr;
  logic [NUM_PATH-1:0] p_force;
  logic [NUM_PATH-1:0] p_pin_in;
  logic [NUM_PATH-1:0] p_mach_d;
  logic [NUM_PATH-1:0] p_mach_q;
  logic [NUM_PATH-1:0] p_pin_out;
  logic [NUM_PATH-1:0] p_pin_oe;
  logic [NUM_PATH-1:0] p_act;
  logic [NUM_PATH-1:0] p_stb;

  refsw_auto_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .ok_a   (ref_a_ok),
    .ok_b   (ref_b_ok),
    .pick_d (fsm_d),
    .pick_q (fsm_q)
  );

  always_comb begin
    p_auto[PATH_SEL]    = auto_sel_en;
    p_ovr[PATH_SEL]     = sel_ovr_en;
    p_force[PATH_SEL]   = force_ref_b;
    p_pin_in[PATH_SEL]  = sel_pin_i;
    p_mach_d[PATH_SEL]  = fsm_d.ref_b;
    p_mach_q[PATH_SEL]  = fsm_q.ref_b;
    p_auto[PATH_HOLD]   = auto_hold_en;
    p_ovr[PATH_HOLD]    = hold_ovr_en;
    p_force[PATH_HOLD]  = force_hold;
    p_pin_in[PATH_HOLD] = hold_pin_i;
    p_mach_d[PATH_HOLD] = fsm_d.hold;
    p_mach_q[PATH_HOLD] = fsm_q.hold;
  end

  for (genvar gi = 0; gi < NUM_PATH; gi++) begin : g_path
    refsw_path u_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .auto_en (p_auto[gi]),
      .ovr_en  (p_ovr[gi]),
      .ovr_val (p_force[gi]),
      .pin_in  (p_pin_in[gi]),
      .mach_d  (p_mach_d[gi]),
      .mach_q  (p_mach_q[gi]),
      .pin_out (p_pin_out[gi]),
      .pin_oe  (p_pin_oe[gi]),
      .act_q   (p_act[gi]),
      .chg_stb (p_stb[gi])
    );
  end

  assign sel_pin_o    = p_pin_out[PATH_SEL];
  assign sel_pin_oe   = p_pin_oe[PATH_SEL];
  assign hold_pin_o   = p_pin_out[PATH_HOLD];
  assign hold_pin_oe  = p_pin_oe[PATH_HOLD];
  assign act_ref_b    = p_act[PATH_SEL];
  assign act_hold     = p_act[PATH_HOLD];
  assign sel_chg_stb  = p_stb[PATH_SEL];
  assign hold_chg_stb = p_stb[PATH_HOLD];

endmodule

// File: rtl/refsw_ctrl_chk.sv
module refsw_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_a_ok,
  input logic ref_b_ok,
  input logic auto_sel_en,
  input logic auto_hold_en,
  input logic sel_ovr_en,
  input logic hold_ovr_en,
  input logic force_ref_b,
  input logic force_hold,
  input logic sel_pin_i,
  input logic sel_pin_o,
  input logic hold_pin_i,
  input logic hold_pin_o,
  input logic act_ref_b,
  input logic act_hold,
  input logic sel_chg_stb,
  input logic hold_chg_stb
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!act_ref_b && !act_hold && !sel_chg_stb && !hold_chg_stb && !sel_pin_o && !hold_pin_o); // R1
    end
  end

  AST_MANUAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_sel_en && !sel_ovr_en) |=> (act_ref_b == $past(sel_pin_i))); // R2

  AST_AUTO_SEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_sel_en && !sel_ovr_en) |=> (act_ref_b == sel_pin_o)); // R3

  AST_FORCED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ovr_en |=> (act_ref_b == $past(force_ref_b))); // R4

  AST_FORCED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ovr_en |=> (act_hold == $past(force_hold))); // R5

  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_hold_en && !hold_ovr_en) |=> (act_hold == $past(hold_pin_i))); // R5

  AST_STAY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_pin_o && (sel_pin_o ? ref_b_ok : ref_a_ok)) |=> ($stable(sel_pin_o) && !hold_pin_o)); // R6

  AST_BOTH_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_a_ok && !ref_b_ok) |=> hold_pin_o); // R7

  AST_EXIT_PREFERS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_pin_o && ref_a_ok) |=> (!hold_pin_o && !sel_pin_o)); // R8

  AST_SEL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg_stb == (act_ref_b != $past(act_ref_b))); // R9

  AST_HOLD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_chg_stb == (act_hold != $past(act_hold))); // R9

endmodule

bind refsw_ctrl refsw_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_a_ok     (ref_a_ok),
  .ref_b_ok     (ref_b_ok),
  .auto_sel_en  (auto_sel_en),
  .auto_hold_en (auto_hold_en),
  .sel_ovr_en   (sel_ovr_en),
  .hold_ovr_en  (hold_ovr_en),
  .force_ref_b  (force_ref_b),
  .force_hold   (force_hold),
  .sel_pin_i    (sel_pin_i),
  .sel_pin_o    (sel_pin_o),
  .hold_pin_i   (hold_pin_i),
  .hold_pin_o   (hold_pin_o),
  .act_ref_b    (act_ref_b),
  .act_hold     (act_hold),
  .sel_chg_stb  (sel_chg_stb),
  .hold_chg_stb (hold_chg_stb)
);

// File: tb/refsw_ctrl_tb_top.sv
`timescale 1ns/1ps
module refsw_ctrl_tb_top;

  logic clk;
  logic rst_n;
  logic ref_a_ok, ref_b_ok;
  logic auto_sel_en, auto_hold_en;
  logic sel_ovr_en, hold_ovr_en;
  logic force_ref_b, force_hold;
  logic sel_pin_i, hold_pin_i;
  logic sel_pin_o, sel_pin_oe, hold_pin_o, hold_pin_oe;
  logic act_ref_b, act_hold, sel_chg_stb, hold_chg_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  refsw_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_a_ok     (ref_a_ok),
    .ref_b_ok     (ref_b_ok),
    .auto_sel_en  (auto_sel_en),
    .auto_hold_en (auto_hold_en),
    .sel_ovr_en   (sel_ovr_en),
    .hold_ovr_en  (hold_ovr_en),
    .force_ref_b  (force_ref_b),
    .force_hold   (force_hold),
    .sel_pin_i    (sel_pin_i),
    .sel_pin_o    (sel_pin_o),
    .sel_pin_oe   (sel_pin_oe),
    .hold_pin_i   (hold_pin_i),
    .hold_pin_o   (hold_pin_o),
    .hold_pin_oe  (hold_pin_oe),
    .act_ref_b    (act_ref_b),
    .act_hold     (act_hold),
    .sel_chg_stb  (sel_chg_stb),
    .hold_chg_stb (hold_chg_stb)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got=%b exp=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  // one rising edge, then sample just after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ref_a_ok = 1'b1; ref_b_ok = 1'b1;
    auto_sel_en = 1'b0; auto_hold_en = 1'b1;
    sel_ovr_en = 1'b0; hold_ovr_en = 1'b0;
    force_ref_b = 1'b0; force_hold = 1'b0;
    sel_pin_i = 1'b0; hold_pin_i = 1'b0;
    repeat (3) step();
    chk(act_ref_b, 1'b0, "R1", "act_ref_b in reset");
    chk(act_hold, 1'b0, "R1", "act_hold in reset");
    chk(sel_chg_stb | hold_chg_stb, 1'b0, "R1", "strobes in reset");
    chk(sel_pin_o | hold_pin_o, 1'b0, "R1", "pins in reset");
    rst_n = 1'b1;
    step();
    chk(act_ref_b, 1'b0, "R1", "act_ref_b after release");
    chk(act_hold, 1'b0, "R1", "act_hold after release");
    chk(sel_chg_stb, 1'b0, "R1", "sel strobe after release");
  endtask

  task automatic t_manual_sel();
    sel_pin_i = 1'b1;
    step();
    chk(sel_pin_oe, 1'b0, "R2", "pin not driven in manual");
    chk(act_ref_b, 1'b1, "R2", "manual pick B");
    chk(sel_chg_stb, 1'b1, "R9", "sel strobe on change");
    step();
    chk(sel_chg_stb, 1'b0, "R9", "sel strobe one cycle");
    chk(act_ref_b, 1'b1, "R2", "manual B held");
    sel_pin_i = 1'b0;
    step();
    chk(act_ref_b, 1'b0, "R2", "manual pick A");
    chk(sel_chg_stb, 1'b1, "R9", "sel strobe back to A");
  endtask

  task automatic t_auto_switch();
    auto_sel_en = 1'b1;
    step();
    chk(sel_pin_oe, 1'b1, "R3", "pin driven in auto");
    chk(sel_pin_o, 1'b0, "R3", "machine on A");
    chk(act_ref_b, 1'b0, "R3", "act on A");
    ref_a_ok = 1'b0;
    step();
    chk(sel_pin_o, 1'b1, "R6", "machine moves to B");
    chk(act_ref_b, 1'b1, "R3", "act follows machine");
    chk(sel_chg_stb, 1'b1, "R9", "strobe on auto switch");
    ref_a_ok = 1'b1;
    step();
    chk(act_ref_b, 1'b1, "R6", "stays on valid B");
    chk(sel_chg_stb, 1'b0, "R9", "no strobe without change");
  endtask

  task automatic t_holdover();
    ref_a_ok = 1'b0; ref_b_ok = 1'b0;
    step();
    chk(act_hold, 1'b1, "R7", "enter holdover");
    chk(hold_pin_o, 1'b1, "R7", "hold pin reports");
    chk(act_ref_b, 1'b1, "R7", "reference kept in holdover");
    chk(hold_chg_stb, 1'b1, "R9", "hold strobe");
    step();
    chk(hold_chg_stb, 1'b0, "R9", "hold strobe one cycle");
    ref_b_ok = 1'b1;
    step();
    chk(act_hold, 1'b0, "R8", "exit to B");
    chk(act_ref_b, 1'b1, "R8", "B chosen on exit");
    ref_b_ok = 1'b0;
    step();
    chk(act_hold, 1'b1, "R7", "re-enter holdover");
    ref_a_ok = 1'b1; ref_b_ok = 1'b1;
    step();
    chk(act_hold, 1'b0, "R8", "exit on tie");
    chk(act_ref_b, 1'b0, "R8", "A preferred on tie");
    chk(sel_chg_stb, 1'b1, "R9", "strobe on tie exit");
  endtask

  task automatic t_sel_override();
    sel_ovr_en = 1'b1; force_ref_b = 1'b1;
    step();
    chk(act_ref_b, 1'b1, "R4", "forced to B");
    chk(sel_pin_o, 1'b0, "R4", "pin still shows A");
    ref_a_ok = 1'b0;
    step();
    chk(sel_pin_o, 1'b1, "R4", "pin shows machine switch");
    chk(act_ref_b, 1'b1, "R4", "forced value kept");
    chk(sel_chg_stb, 1'b0, "R9", "no strobe when act steady");
    ref_a_ok = 1'b1; force_ref_b = 1'b0;
    step();
    chk(act_ref_b, 1'b0, "R4", "forced to A");
    chk(sel_pin_o, 1'b1, "R6", "machine stays on B");
    sel_ovr_en = 1'b0;
    step();
    chk(act_ref_b, 1'b1, "R3", "back to machine choice");
  endtask

  task automatic t_hold_override();
    hold_ovr_en = 1'b1; force_hold = 1'b1;
    step();
    chk(act_hold, 1'b1, "R5", "forced holdover");
    chk(hold_pin_o, 1'b0, "R5", "hold pin shows machine");
    ref_a_ok = 1'b0; ref_b_ok = 1'b0;
    step();
    chk(hold_pin_o, 1'b1, "R5", "machine holdover reported");
    chk(hold_chg_stb, 1'b0, "R9", "no hold strobe");
    force_hold = 1'b0;
    step();
    chk(act_hold, 1'b0, "R5", "forced out of holdover");
    chk(hold_pin_o, 1'b1, "R5", "pin still machine hold");
    hold_ovr_en = 1'b0;
    step();
    chk(act_hold, 1'b1, "R5", "back to machine hold");
    ref_a_ok = 1'b1; ref_b_ok = 1'b1;
    step();
    chk(act_hold, 1'b0, "R8", "leave hold");
    chk(act_ref_b, 1'b0, "R8", "A on tie from B hold");
  endtask

  task automatic t_hold_manual();
    auto_hold_en = 1'b0; hold_pin_i = 1'b1;
    step();
    chk(hold_pin_oe, 1'b0, "R5", "hold pin not driven");
    chk(act_hold, 1'b1, "R5", "manual holdover");
    hold_pin_i = 1'b0;
    step();
    chk(act_hold, 1'b0, "R5", "manual release");
    auto_hold_en = 1'b1;
    step();
    chk(hold_pin_oe, 1'b1, "R5", "hold pin driven in auto");
  endtask

  initial begin
    t_reset();
    t_manual_sel();
    t_auto_switch();
    t_holdover();
    t_sel_override();
    t_hold_override();
    t_hold_manual();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule